// File: doc/BRIEF.md
# Programmable Per-Lane Word Aligner

This block sits behind a 1:10 deserializer in a three-lane TMDS video receiver. Every pixel clock it takes one raw 10-bit word from each lane. The deserializer's word edges are arbitrary, so the block re-frames each lane's bit stream to a bit offset chosen by the user. It then presents three aligned 10-bit words together with a valid flag.

Each lane holds its own offset, written through a small register write port and readable at all times on a readback bus. The offset is an absolute value, not a one-way slip pulse. A lane can be stepped one bit later or earlier and then returned to an earlier setting, and the alignment it gives is exactly the same as before. Any lane can move without disturbing the other lanes.

The block does not search for sync words itself. Logic outside, or software, picks the offsets.

Top module: `word_aligner`

## Requirements
- R1: The three lanes are independent. Lane n takes its raw word on `raw_words[10n+9:10n]` and drives `aligned_words[10n+9:10n]`. A write addressed to lane n (`cfg_lane` = n, n in 0..2) changes only that lane's offset and output.
- R2: Bit 0 of a raw word is the earliest bit received on the wire and bit 9 is the latest. On the output, bit 0 is likewise the earliest bit.
- R3: With offset s, output bit i is the stream bit that lies i − s bit times after the first bit of the current word. The offset therefore delays the stream by s bits, and lowering it by one advances the stream by one bit.
- R4: The offset is absolute. Moving a lane from 5 to 4, then to 6, then back to 5 gives the same output words as the first setting of 5.
- R5: Legal offsets are 0 to 9. A write with `cfg_shift` above 9, or with `cfg_lane` equal to 3, changes no offset and no output.
- R6: A legal write sampled on clock edge e is first used for the output word registered on edge e+1. Every output word is formed from a single offset.
- R7: With offset 0, `aligned_words` equals `raw_words` as sampled two clock edges earlier. Every offset has the same two-clock latency.
- R8: During and after reset, every offset reads 0 and `aligned_valid` is low. `aligned_valid` goes high after the third rising edge that follows reset release and then stays high.
- R9: `shift_rb[4n+3:4n]` always shows the current offset of lane n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; one raw word per lane per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_words | input | 30 | Raw deserializer words, lane n at bits 10n+9:10n |
| cfg_we | input | 1 | Offset write strobe |
| cfg_lane | input | 2 | Lane addressed by the write |
| cfg_shift | input | 4 | Offset value to write |
| aligned_words | output | 30 | Re-framed words, lane n at bits 10n+9:10n |
| aligned_valid | output | 1 | High once the two-word window holds real data |
| shift_rb | output | 12 | Current offset of each lane, lane n at bits 4n+3:4n |

## Verification
The bench feeds constant marker words, for which the correct output is a single bit that sits at position s. A wrong select direction or a wrong LSB order would put that bit at 9 − s, or on the wrong word. It steps one lane through 5, 4, 6 and back to 5 while the other lanes hold different offsets. An incremental slip, or a shared offset register, would then fail to return to the first word or would move a neighbouring lane. It makes writes that are out of range and writes to lane 3, which a missing guard would accept. It also samples on both sides of the edge where a new offset starts to act, so an off-by-one delay, or an output word that mixes two offsets, shows up against the cycle-by-cycle model.

// File: rtl/word_align_pkg.sv
package word_align_pkg;

    localparam int DEF_LANES  = 3;
    localparam int DEF_WORD_W = 10;

    // Start-up tracking for the output-valid flag
    typedef struct packed {
        logic [1:0] fill;
        logic       valid;
    } fill_state_t;

endpackage

// File: rtl/word_align_lane.sv
module word_align_lane #(
    parameter int WORD_W  = 10,
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  raw_word,
    input  logic [SHIFT_W-1:0] shift,
    output logic [WORD_W-1:0]  aligned_word
);

    localparam int WIN_W  = 2 * WORD_W;
    localparam int BASE_W = $clog2(WIN_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] cur;
        logic [WORD_W-1:0] prev;
        logic [WORD_W-1:0] out;
    } lane_st_t;

    lane_st_t           st_d, st_q;
    logic [WIN_W-1:0]   window_d;
    logic [BASE_W-1:0]  base_d;

    always_comb begin
        st_d     = st_q;
        // Older word in the low half: earliest bit sits at index 0
        window_d = {st_q.cur, st_q.prev};
        // Offset s pulls s trailing bits of the older word in front
        base_d   = BASE_W'(WORD_W) - BASE_W'(shift);
        st_d.out = WORD_W'(window_d >> base_d);
        st_d.prev = st_q.cur;
        st_d.cur  = raw_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign aligned_word = st_q.out;

endmodule

// File: rtl/word_align_shifts.sv
module word_align_shifts #(
    parameter int LANES   = 3,
    parameter int WORD_W  = 10,
    parameter int SHIFT_W = 4,
    parameter int LANE_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [LANE_W-1:0]             wr_lane,
    input  logic [SHIFT_W-1:0]            wr_shift,
    output logic [LANES-1:0][SHIFT_W-1:0] shifts
);

    typedef struct packed {
        logic [LANES-1:0][SHIFT_W-1:0] sh;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      legal_d;

    always_comb begin
        st_d    = st_q;
        legal_d = wr_en
                  && (int'(wr_lane) < LANES)
                  && (int'(wr_shift) < WORD_W);
        for (int l = 0; l < LANES; l++) begin
            if (legal_d && (int'(wr_lane) == l)) begin
                st_d.sh[l] = wr_shift;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shifts = st_q.sh;

endmodule

// File: rtl/word_aligner.sv
module word_aligner
    import word_align_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [LANES*WORD_W-1:0]               raw_words,
    input  logic                                  cfg_we,
    input  logic [$clog2(LANES+1)-1:0]            cfg_lane,
    input  logic [$clog2(WORD_W)-1:0]             cfg_shift,
    output logic [LANES*WORD_W-1:0]               aligned_words,
    output logic                                  aligned_valid,
    output logic [LANES*$clog2(WORD_W)-1:0]       shift_rb
);

    localparam int SHIFT_W = $clog2(WORD_W);
    localparam int LANE_W  = $clog2(LANES + 1);

    logic [LANES-1:0][SHIFT_W-1:0] lane_shift;
    fill_state_t                   fill_d, fill_q;

    word_align_shifts #(
        .LANES   (LANES),
        .WORD_W  (WORD_W),
        .SHIFT_W (SHIFT_W),
        .LANE_W  (LANE_W)
    ) u_shifts (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_lane  (cfg_lane),
        .wr_shift (cfg_shift),
        .shifts   (lane_shift)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        word_align_lane #(
            .WORD_W  (WORD_W),
            .SHIFT_W (SHIFT_W)
        ) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .raw_word     (raw_words[g*WORD_W +: WORD_W]),
            .shift        (lane_shift[g]),
            .aligned_word (aligned_words[g*WORD_W +: WORD_W])
        );
        assign shift_rb[g*SHIFT_W +: SHIFT_W] = lane_shift[g];
    end

    // Valid once the output was built from two genuinely received words
    always_comb begin
        fill_d       = fill_q;
        fill_d.valid = (fill_q.fill == 2'd2);
        if (fill_q.fill != 2'd2) begin
            fill_d.fill = fill_q.fill + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
        end
    end

    assign aligned_valid = fill_q.valid;

endmodule

// File: rtl/word_aligner_checks.sv
module word_aligner_checks #(
    parameter int LANES  = 3,
    parameter int WORD_W = 10
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [LANES*WORD_W-1:0]             raw_words,
    input logic                                cfg_we,
    input logic [$clog2(LANES+1)-1:0]          cfg_lane,
    input logic [$clog2(WORD_W)-1:0]           cfg_shift,
    input logic [LANES*WORD_W-1:0]             aligned_words,
    input logic                                aligned_valid,
    input logic [LANES*$clog2(WORD_W)-1:0]     shift_rb
);

    localparam int SW = $clog2(WORD_W);

    AST_VALID_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        aligned_valid |=> aligned_valid); // R8

    AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_shift) >= WORD_W || int'(cfg_lane) >= LANES))
        |=> $stable(shift_rb)); // R5

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        AST_SHIFT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            int'(shift_rb[l*SW +: SW]) < WORD_W); // R5

        AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && int'(cfg_lane) == l && int'(cfg_shift) < WORD_W)
            |=> shift_rb[l*SW +: SW] == $past(cfg_shift)); // R9

        AST_OTHER_LANE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && int'(cfg_lane) != l) |=> $stable(shift_rb[l*SW +: SW])); // R1

        AST_ZERO_SHIFT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (aligned_valid && $past(shift_rb[l*SW +: SW]) == '0)
            |-> aligned_words[l*WORD_W +: WORD_W]
                == $past(raw_words[l*WORD_W +: WORD_W], 2)); // R7

        AST_LANE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
            aligned_valid |-> aligned_words[l*WORD_W +: WORD_W] == WORD_W'(
                {$past(raw_words[l*WORD_W +: WORD_W], 2),
                 $past(raw_words[l*WORD_W +: WORD_W], 3)}
                >> (WORD_W - int'($past(shift_rb[l*SW +: SW]))))); // R3
    end

endmodule

bind word_aligner word_aligner_checks #(
    .LANES  (LANES),
    .WORD_W (WORD_W)
) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .raw_words     (raw_words),
    .cfg_we        (cfg_we),
    .cfg_lane      (cfg_lane),
    .cfg_shift     (cfg_shift),
    .aligned_words (aligned_words),
    .aligned_valid (aligned_valid),
    .shift_rb      (shift_rb)
);

// File: tb/word_aligner_bench.sv
module word_aligner_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 3;
    localparam int W  = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL*W-1:0] raw_words = '0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_lane = '0;
    logic [3:0]      cfg_shift = '0;
    logic [NL*W-1:0] aligned_words;
    logic            aligned_valid;
    logic [NL*4-1:0] shift_rb;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    const_mode = 1'b0;
    logic [W-1:0] const_word = '0;
    string cur_tag = "R7";
    bit    model_on = 1'b0;

    // reference model state
    logic [W-1:0] cur_m [NL];
    logic [W-1:0] prev_m[NL];
    logic [W-1:0] exp_w [NL];
    int           shm   [NL];
    int           fill_m;
    bit           exp_v;

    word_aligner u_word_aligner (
        .clk           (clk),
        .rst_n         (rst_n),
        .raw_words     (raw_words),
        .cfg_we        (cfg_we),
        .cfg_lane      (cfg_lane),
        .cfg_shift     (cfg_shift),
        .aligned_words (aligned_words),
        .aligned_valid (aligned_valid),
        .shift_rb      (shift_rb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Behavioural model: a bit stream per lane, offset delays it
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NL; l++) begin
                cur_m[l] = '0; prev_m[l] = '0; exp_w[l] = '0; shm[l] = 0;
            end
            fill_m = 0;
            exp_v  = 1'b0;
        end else begin
            for (int l = 0; l < NL; l++) begin
                for (int i = 0; i < W; i++) begin
                    int j;
                    j = i + W - shm[l];
                    exp_w[l][i] = (j < W) ? prev_m[l][j] : cur_m[l][j-W];
                end
            end
            exp_v = (fill_m >= 2);
            if (fill_m < 2) fill_m++;
            for (int l = 0; l < NL; l++) begin
                prev_m[l] = cur_m[l];
                cur_m[l]  = raw_words[l*W +: W];
            end
            if (cfg_we && cfg_lane < 2'd3 && cfg_shift <= 4'd9)
                shm[cfg_lane] = int'(cfg_shift);
        end
    end

    // Stimulus words change away from the sampling edge
    always @(negedge clk) begin
        if (const_mode) raw_words <= {NL{const_word}};
        else            raw_words <= {$urandom, $urandom};
    end

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            logic [NL*W-1:0] ew;
            logic [NL*4-1:0] er;
            for (int l = 0; l < NL; l++) begin
                ew[l*W +: W] = exp_w[l];
                er[l*4 +: 4] = 4'(shm[l]);
            end
            check(cur_tag, "model words", 64'(aligned_words), 64'(ew));
            check("R9", "model readback", 64'(shift_rb), 64'(er));
            check("R8", "model valid", 64'(aligned_valid), 64'(exp_v));
        end
    end

    task automatic write_shift(input int lane, input int val);
        cfg_we    = 1'b1;
        cfg_lane  = 2'(lane);
        cfg_shift = 4'(val);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    function automatic logic [W-1:0] lane_out(input int l);
        return aligned_words[l*W +: W];
    endfunction

    initial begin
        logic [W-1:0] first5;
        logic [NL*4-1:0] rb_before;
        logic [NL*W-1:0] out_before;
        repeat (3) @(negedge clk);
        check("R8", "valid in reset", 64'(aligned_valid), 64'd0);
        check("R8", "offsets in reset", 64'(shift_rb), 64'd0);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk); // edge 1
        check("R8", "valid after edge 1", 64'(aligned_valid), 64'd0);
        @(negedge clk); // edge 2
        check("R8", "valid after edge 2", 64'(aligned_valid), 64'd0);
        @(negedge clk); // edge 3
        check("R8", "valid after edge 3", 64'(aligned_valid), 64'd1);

        cur_tag = "R7";
        repeat (20) @(negedge clk);

        cur_tag = "R3";
        write_shift(0, 1);
        write_shift(1, 7);
        write_shift(2, 9);
        repeat (20) @(negedge clk);
        cur_tag = "R6";
        write_shift(1, 2);
        write_shift(1, 8);
        write_shift(0, 0);
        repeat (10) @(negedge clk);

        // Marker word: one set bit per word at bit 0
        const_mode = 1'b1;
        const_word = 10'h001;
        cur_tag = "R4";
        write_shift(0, 6);
        write_shift(1, 5);
        write_shift(2, 4);
        repeat (4) @(negedge clk);
        first5 = lane_out(1);
        check("R3", "lane1 offset 5", 64'(first5), 64'h020);
        check("R1", "lane0 offset 6", 64'(lane_out(0)), 64'h040);
        check("R1", "lane2 offset 4", 64'(lane_out(2)), 64'h010);
        write_shift(1, 4);
        repeat (3) @(negedge clk);
        check("R3", "lane1 advanced to 4", 64'(lane_out(1)), 64'h010);
        check("R1", "lane0 untouched", 64'(lane_out(0)), 64'h040);
        write_shift(1, 6);
        repeat (3) @(negedge clk);
        check("R3", "lane1 delayed to 6", 64'(lane_out(1)), 64'h040);
        write_shift(1, 5);
        repeat (3) @(negedge clk);
        check("R4", "lane1 back at 5", 64'(lane_out(1)), 64'(first5));

        // Timing of a new offset: not yet one edge after the write
        cur_tag = "R6";
        write_shift(2, 3);
        check("R6", "old offset one edge later", 64'(lane_out(2)), 64'h010);
        @(negedge clk);
        check("R6", "new offset two edges later", 64'(lane_out(2)), 64'h008);

        // LSB is the earliest bit: last bit of a word lands at bit 0
        const_word = 10'h200;
        repeat (3) @(negedge clk);
        write_shift(0, 1);
        repeat (3) @(negedge clk);
        check("R2", "bit 9 delayed to bit 0", 64'(lane_out(0)), 64'h001);
        write_shift(0, 0);
        repeat (3) @(negedge clk);
        check("R2", "offset 0 keeps bit 9", 64'(lane_out(0)), 64'h200);

        // Illegal writes change nothing
        cur_tag = "R5";
        rb_before  = shift_rb;
        out_before = aligned_words;
        write_shift(0, 12);
        write_shift(1, 15);
        write_shift(3, 7);
        repeat (3) @(negedge clk);
        check("R5", "readback after bad writes", 64'(shift_rb), 64'(rb_before));
        check("R5", "words after bad writes", 64'(aligned_words), 64'(out_before));
        check("R9", "lane2 readback", 64'(shift_rb[8 +: 4]), 64'd3);

        const_mode = 1'b0;
        cur_tag = "R3";
        write_shift(0, 9);
        repeat (30) @(negedge clk);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule